// File: doc/BRIEF.md
# Byte/Word Data Lane Steering

This block sits between the external data pins of a 16-bit memory card and the two byte halves of its internal memory word. The card may be attached to a 16-bit host, which moves both bytes together, or to an 8-bit host, which moves single bytes. The block works out which internal byte each external byte lane carries and when each lane may drive. It also forms the per-byte write strobes for the array.

Each half of the word has its own active-low card enable. The host uses an active-low output enable and an active-low write enable. In byte mode only the low half's enable is asserted, and address bit A0 picks the byte. When A0 is low, the even (low) byte uses the low pins. When A0 is high, the odd (high) internal byte is moved across to the low pins.

If only the high half's enable is asserted, the high byte uses its own pins. If both enables are asserted, both bytes move at once. Every output is registered, so it reflects the inputs sampled one clock earlier.

Top module: `card_lane_steer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, both lane output enables, both write strobes and both select flags are 0, both standby flags are 1, and the pin data outputs are 0.
- R2: With `ce_lo_n`=0, `ce_hi_n`=1, `a0`=0, `oe_n`=0 and `we_n`=1, `lo_oe`=1 and `lo_dout` equals `arr_lo`. `hi_oe`=0.
- R3: With `ce_lo_n`=0, `ce_hi_n`=1, `a0`=1 and a read (`oe_n`=0, `we_n`=1), `lo_dout` equals `arr_hi` (the odd byte moved to the low pins), `lo_oe`=1 and `hi_oe`=0.
- R4: With `ce_hi_n`=0 and `ce_lo_n`=1, a read gives `hi_oe`=1 with `hi_dout`=`arr_hi`, and `lo_oe`=0, whatever the level of `a0`.
- R5: With both enables low, a read drives both lanes at once: `lo_dout`=`arr_lo` and `hi_dout`=`arr_hi`, whatever the level of `a0`.
- R6: A lane drives only when `oe_n`=0 and `we_n`=1. Otherwise its output enable is 0 and its data output is 0.
- R7: `lo_stby` follows `ce_lo_n` and `hi_stby` follows `ce_hi_n`. A half in standby never drives its lane, whatever the level of `oe_n`.
- R8: A write is `we_n`=0 with `oe_n`=1. In byte mode the write pulses `lo_we` with `wr_lo`=`lo_din` when `a0`=0. It pulses `hi_we` with `wr_hi`=`lo_din` when `a0`=1.
- R9: A write with only `ce_hi_n` low pulses `hi_we` with `wr_hi`=`hi_din`. A write with both enables low pulses both strobes with `wr_lo`=`lo_din` and `wr_hi`=`hi_din`. Neither case depends on `a0`.
- R10: Every output reflects the inputs sampled at the previous rising clock edge: a latency of exactly one cycle.
- R11: `lo_sel` is 1 when the access targets the low internal byte, and `hi_sel` is 1 when it targets the high internal byte. Both follow the enables and `a0` alone, whether the cycle is a read, a write or neither.
- R12: A write strobe and a lane output enable are never both 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_lo_n | input | 1 | Active-low enable, low half |
| ce_hi_n | input | 1 | Active-low enable, high half |
| a0 | input | 1 | Byte address bit (byte mode only) |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| arr_lo | input | DW | Internal low byte read from the array |
| arr_hi | input | DW | Internal high byte read from the array |
| lo_din | input | DW | Data received on the low pins |
| hi_din | input | DW | Data received on the high pins |
| lo_dout | output | DW | Data to drive on the low pins |
| lo_oe | output | 1 | Drive enable, low pins |
| hi_dout | output | DW | Data to drive on the high pins |
| hi_oe | output | 1 | Drive enable, high pins |
| wr_lo | output | DW | Write data for the internal low byte |
| wr_hi | output | DW | Write data for the internal high byte |
| lo_we | output | 1 | Write strobe, internal low byte |
| hi_we | output | 1 | Write strobe, internal high byte |
| lo_sel | output | 1 | Internal low byte targeted |
| hi_sel | output | 1 | Internal high byte targeted |
| lo_stby | output | 1 | Low half in standby |
| hi_stby | output | 1 | High half in standby |

## Verification
The hardest case to reach is the odd-byte cross path. Here the high internal byte must leave on the low pins while the high lane stays quiet. On a write, low-pin data must land in the high byte with only the high strobe set. A fault that swaps or merges lanes is invisible when both bytes hold the same value. The stimulus therefore sweeps all 32 combinations of the five control inputs, and it gives the two array bytes and the two pin inputs distinct values in every pass. It also changes the inputs on every cycle, so that any output held one cycle too long, or taken from the wrong edge, shows up as a miscompare.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [2:0] {
    LM_OFF   = 3'd0,
    LM_EVEN  = 3'd1,
    LM_ODD   = 3'd2,
    LM_UPPER = 3'd3,
    LM_WORD  = 3'd4
  } lane_mode_t;
endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import lane_pkg::*;
(
  input  logic       ce_lo_n,
  input  logic       ce_hi_n,
  input  logic       a0,
  input  logic       oe_n,
  input  logic       we_n,
  output lane_mode_t mode,
  output logic       rd_en,
  output logic       wr_en
);
  always_comb begin
    unique case ({ce_hi_n, ce_lo_n})
      2'b10:   mode = a0 ? LM_ODD : LM_EVEN;
      2'b01:   mode = LM_UPPER;
      2'b00:   mode = LM_WORD;
      default: mode = LM_OFF;
    endcase
  end

  assign rd_en = !oe_n && we_n;
  assign wr_en = !we_n && oe_n;
endmodule

// File: rtl/read_steer.sv
module read_steer
  import lane_pkg::*;
#(
  parameter int DW = 8
) (
  input  lane_mode_t    mode,
  input  logic          rd_en,
  input  logic [DW-1:0] arr_lo,
  input  logic [DW-1:0] arr_hi,
  output logic          lo_oe,
  output logic [DW-1:0] lo_dout,
  output logic          hi_oe,
  output logic [DW-1:0] hi_dout
);
  always_comb begin
    lo_oe   = 1'b0;
    hi_oe   = 1'b0;
    lo_dout = '0;
    hi_dout = '0;
    if (rd_en) begin
      unique case (mode)
        LM_EVEN:  begin lo_oe = 1'b1; lo_dout = arr_lo; end
        LM_ODD:   begin lo_oe = 1'b1; lo_dout = arr_hi; end
        LM_UPPER: begin hi_oe = 1'b1; hi_dout = arr_hi; end
        LM_WORD:  begin
          lo_oe = 1'b1; lo_dout = arr_lo;
          hi_oe = 1'b1; hi_dout = arr_hi;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/write_steer.sv
module write_steer
  import lane_pkg::*;
#(
  parameter int DW = 8
) (
  input  lane_mode_t    mode,
  input  logic          wr_en,
  input  logic [DW-1:0] lo_din,
  input  logic [DW-1:0] hi_din,
  output logic          lo_we,
  output logic          hi_we,
  output logic [DW-1:0] wr_lo,
  output logic [DW-1:0] wr_hi,
  output logic          lo_sel,
  output logic          hi_sel
);
  always_comb begin
    lo_sel = (mode == LM_EVEN) || (mode == LM_WORD);
    hi_sel = (mode == LM_ODD) || (mode == LM_UPPER) || (mode == LM_WORD);
  end

  assign lo_we = wr_en && lo_sel;
  assign hi_we = wr_en && hi_sel;
  assign wr_lo = lo_din;
  assign wr_hi = (mode == LM_ODD) ? lo_din : hi_din;
endmodule

// File: rtl/card_lane_steer.sv
module card_lane_steer
  import lane_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_lo_n,
  input  logic          ce_hi_n,
  input  logic          a0,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [DW-1:0] arr_lo,
  input  logic [DW-1:0] arr_hi,
  input  logic [DW-1:0] lo_din,
  input  logic [DW-1:0] hi_din,
  output logic [DW-1:0] lo_dout,
  output logic          lo_oe,
  output logic [DW-1:0] hi_dout,
  output logic          hi_oe,
  output logic [DW-1:0] wr_lo,
  output logic [DW-1:0] wr_hi,
  output logic          lo_we,
  output logic          hi_we,
  output logic          lo_sel,
  output logic          hi_sel,
  output logic          lo_stby,
  output logic          hi_stby
);
  lane_mode_t    mode;
  logic          rd_en, wr_en;
  logic          n_lo_oe, n_hi_oe, n_lo_we, n_hi_we, n_lo_sel, n_hi_sel;
  logic [DW-1:0] n_lo_d, n_hi_d, n_wr_lo, n_wr_hi;

  lane_decode u_dec (
    .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .a0(a0), .oe_n(oe_n), .we_n(we_n),
    .mode(mode), .rd_en(rd_en), .wr_en(wr_en)
  );

  read_steer #(.DW(DW)) u_rd (
    .mode(mode), .rd_en(rd_en), .arr_lo(arr_lo), .arr_hi(arr_hi),
    .lo_oe(n_lo_oe), .lo_dout(n_lo_d), .hi_oe(n_hi_oe), .hi_dout(n_hi_d)
  );

  write_steer #(.DW(DW)) u_wr (
    .mode(mode), .wr_en(wr_en), .lo_din(lo_din), .hi_din(hi_din),
    .lo_we(n_lo_we), .hi_we(n_hi_we), .wr_lo(n_wr_lo), .wr_hi(n_wr_hi),
    .lo_sel(n_lo_sel), .hi_sel(n_hi_sel)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_dout <= '0;   lo_oe  <= 1'b0;
      hi_dout <= '0;   hi_oe  <= 1'b0;
      wr_lo   <= '0;   wr_hi  <= '0;
      lo_we   <= 1'b0; hi_we  <= 1'b0;
      lo_sel  <= 1'b0; hi_sel <= 1'b0;
      lo_stby <= 1'b1; hi_stby <= 1'b1;
    end else begin
      lo_dout <= n_lo_d;   lo_oe  <= n_lo_oe;
      hi_dout <= n_hi_d;   hi_oe  <= n_hi_oe;
      wr_lo   <= n_wr_lo;  wr_hi  <= n_wr_hi;
      lo_we   <= n_lo_we;  hi_we  <= n_hi_we;
      lo_sel  <= n_lo_sel; hi_sel <= n_hi_sel;
      lo_stby <= ce_lo_n;  hi_stby <= ce_hi_n;
    end
  end

  // R7
  lo_stby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lo_stby |-> !lo_oe);
  // R7
  hi_stby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    hi_stby |-> !hi_oe);
  // R12
  no_drive_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    !((lo_oe || hi_oe) && (lo_we || hi_we)));
  // R6
  drive_needs_read_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_oe || hi_oe) |-> ($past(we_n) && !$past(oe_n)));
  // R9
  dual_strobe_word_chk: assert property (@(posedge clk) disable iff (rst)
    (lo_we && hi_we) |-> (!lo_stby && !hi_stby));
  // R11
  byte_mode_single_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (!lo_stby && hi_stby) |-> $onehot0({lo_sel, hi_sel}));
endmodule

// File: tb/card_lane_steer_bench.sv
module card_lane_steer_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_lo_n = 1'b1, ce_hi_n = 1'b1, a0 = 1'b0, oe_n = 1'b1, we_n = 1'b1;
  logic [DW-1:0] arr_lo = '0, arr_hi = '0, lo_din = '0, hi_din = '0;
  logic [DW-1:0] lo_dout, hi_dout, wr_lo, wr_hi;
  logic lo_oe, hi_oe, lo_we, hi_we, lo_sel, hi_sel, lo_stby, hi_stby;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  card_lane_steer #(.DW(DW)) u_card_lane_steer (
    .clk(clk), .rst(rst), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .a0(a0),
    .oe_n(oe_n), .we_n(we_n), .arr_lo(arr_lo), .arr_hi(arr_hi),
    .lo_din(lo_din), .hi_din(hi_din), .lo_dout(lo_dout), .lo_oe(lo_oe),
    .hi_dout(hi_dout), .hi_oe(hi_oe), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .lo_we(lo_we), .hi_we(hi_we), .lo_sel(lo_sel), .hi_sel(hi_sel),
    .lo_stby(lo_stby), .hi_stby(hi_stby)
  );

  // packed: lo_oe lo_d hi_oe hi_d lo_we hi_we wlo whi lo_sel hi_sel lo_stby hi_stby
  localparam int VW = 8 + 4 * DW;
  typedef struct {
    logic [VW-1:0] v;
    string         tag;
  } item_t;

  item_t sbq[$];

  function automatic logic [VW-1:0] pack_now();
    logic [DW-1:0] wl, wh;
    wl = lo_we ? wr_lo : '0;
    wh = hi_we ? wr_hi : '0;
    return {lo_oe, lo_dout, hi_oe, hi_dout, lo_we, hi_we, wl, wh,
            lo_sel, hi_sel, lo_stby, hi_stby};
  endfunction

  // Expected result from the requirement text
  task automatic drive(input logic cl, input logic chh, input logic ad,
                       input logic o, input logic w, input logic [DW-1:0] al,
                       input logic [DW-1:0] ah, input logic [DW-1:0] dl,
                       input logic [DW-1:0] dh);
    item_t it;
    logic rd, wr, even, odd, up, word;
    logic e_loe, e_hoe, e_lwe, e_hwe, e_ls, e_hs;
    logic [DW-1:0] e_ld, e_hd, e_wl, e_wh;
    @(negedge clk);
    ce_lo_n = cl; ce_hi_n = chh; a0 = ad; oe_n = o; we_n = w;
    arr_lo = al; arr_hi = ah; lo_din = dl; hi_din = dh;
    rd = !o && w;            // R6 read condition
    wr = !w && o;            // R8 write condition
    even = !cl && chh && !ad;
    odd  = !cl && chh && ad;
    up   = cl && !chh;
    word = !cl && !chh;
    e_ls = even || word;     // R11
    e_hs = odd || up || word;
    e_loe = rd && (even || odd || word);
    e_hoe = rd && (up || word);
    e_ld = !e_loe ? '0 : (odd ? ah : al);
    e_hd = e_hoe ? ah : '0;
    e_lwe = wr && e_ls;
    e_hwe = wr && e_hs;
    e_wl = e_lwe ? dl : '0;
    e_wh = !e_hwe ? '0 : (odd ? dl : dh);
    it.v = {e_loe, e_ld, e_hoe, e_hd, e_lwe, e_hwe, e_wl, e_wh,
            e_ls, e_hs, cl, chh};
    if (even)      it.tag = wr ? "R8 even write" : (rd ? "R2 even read" : "R11 even idle");
    else if (odd)  it.tag = wr ? "R8 odd write"  : (rd ? "R3 odd read"  : "R11 odd idle");
    else if (up)   it.tag = wr ? "R9 upper write" : (rd ? "R4 upper read" : "R6 upper idle");
    else if (word) it.tag = wr ? "R9 word write"  : (rd ? "R5 word read"  : "R6 word idle");
    else           it.tag = "R7 standby";
    sbq.push_back(it);
  endtask

  // Monitor: R10, result of inputs set before edge k is read just after edge k
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sbq.size() > 0) begin
        item_t it;
        logic [VW-1:0] got;
        it = sbq.pop_front();
        got = pack_now();
        checks++;
        if (got !== it.v) begin
          fails++;
          $display("FAIL %s (R10 latency): got %h expected %h", it.tag, got, it.v);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [VW-1:0] rst_exp;
    rst_exp = {1'b0, {DW{1'b0}}, 1'b0, {DW{1'b0}}, 2'b00, {2*DW{1'b0}}, 4'b0011};
    // R1: inputs asking for a word read while reset is held
    ce_lo_n = 1'b0; ce_hi_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    arr_lo = 8'h5a; arr_hi = 8'ha5;
    repeat (3) @(posedge clk);
    #5;
    checks++;
    if (pack_now() !== rst_exp) begin
      fails++;
      $display("FAIL R1 reset state: got %h expected %h", pack_now(), rst_exp);
    end
    @(negedge clk);
    rst = 1'b0;
    ce_lo_n = 1'b1; ce_hi_n = 1'b1;
    @(posedge clk);
    #5;
    checks++;
    if (pack_now() !== rst_exp) begin
      fails++;
      $display("FAIL R1 first cycle after reset: got %h expected %h", pack_now(), rst_exp);
    end

    // directed corner cases
    drive(0, 1, 0, 0, 1, 8'h11, 8'hee, 8'h00, 8'h00); // R2
    drive(0, 1, 1, 0, 1, 8'h11, 8'hee, 8'h00, 8'h00); // R3 transposition
    drive(1, 0, 0, 0, 1, 8'h22, 8'hdd, 8'h00, 8'h00); // R4 a0 low
    drive(1, 0, 1, 0, 1, 8'h22, 8'hdd, 8'h00, 8'h00); // R4 a0 high
    drive(0, 0, 1, 0, 1, 8'h33, 8'hcc, 8'h00, 8'h00); // R5
    drive(0, 0, 0, 1, 1, 8'h33, 8'hcc, 8'h00, 8'h00); // R6 oe high
    drive(1, 1, 0, 0, 1, 8'h44, 8'hbb, 8'h00, 8'h00); // R7 oe low, both standby
    drive(0, 1, 0, 1, 0, 8'h00, 8'h00, 8'h6c, 8'h93); // R8 even
    drive(0, 1, 1, 1, 0, 8'h00, 8'h00, 8'h6c, 8'h93); // R8 odd
    drive(1, 0, 1, 1, 0, 8'h00, 8'h00, 8'h6c, 8'h93); // R9 upper
    drive(0, 0, 1, 1, 0, 8'h00, 8'h00, 8'h6c, 8'h93); // R9 word
    drive(0, 0, 0, 0, 0, 8'h33, 8'hcc, 8'h6c, 8'h93); // R12 oe and we both low

    // sweep every control combination with distinct lane values
    for (int pass = 0; pass < 3; pass++) begin
      for (int c = 0; c < 32; c++) begin
        logic [4:0] cv;
        logic [DW-1:0] base;
        cv = 5'(c);
        base = 8'(8'h17 * (c + 1) + pass * 8'h40);
        drive(cv[0], cv[1], cv[2], cv[3], cv[4],
              base, ~base, base ^ 8'h5c, base ^ 8'ha3);
      end
    end
    drive(1, 1, 0, 1, 1, 8'h00, 8'h00, 8'h00, 8'h00);
    wait (sbq.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule